// File: doc/BRIEF.md
# MSI Event Queue Controller

This block receives message-signalled interrupt writes on a posted-write stream and files each one into a per-line ring of 64 words held in an internal RAM. Each ring belongs to one wired interrupt line. The hardware owns the tail pointer, and software owns the head pointer. A line's interrupt output is a level. In event mode it stays high while its ring has unread entries. In batch mode it is raised by a new entry and cleared when software writes the head pointer.

A doorbell address lies inside a 4 KiB message page whose base is a parameter. Inside the page, offset bits [10:8] select the ring, bits [7:2] carry the vector number, and bit 11 must be zero. The data written is normally the vector number. Software uses a small register port to set each ring's control bits, to move head, and to read tail, status and the stored entries. A ring with 63 entries is full, so a further write is dropped and the event is logged in a sticky overflow bit.

The doorbell stream is valid/ready. `db_ready` is low while reset is asserted and stays high after that. A beat is taken on every clock edge where both signals are high, so the source never sees back-pressure once reset has been released. A write that is dropped or ignored still completes its handshake.

Top module: `msi_evq_ctrl`

## Requirements
- R1: After reset every control register, head, tail and overflow bit reads 0 and every `irq` bit is low.
- R2: An accepted doorbell writes the word {10'b0, vector[5:0], data[15:0]} at the ring's tail slot, and tail then advances by one. Stored entries are read through the window at register address {1, ring[2:0], index[5:0]}.
- R3: A doorbell is ignored and no tail changes when its address is outside the message page, has offset bit 11 set, selects ring index 6 or higher, or targets a ring whose enable bit is clear.
- R4: A doorbell to an enabled ring that already holds 63 pending entries is dropped and sets that ring's sticky overflow bit (status register bit 0). Writing 1 to that bit clears it, and writing 0 leaves it unchanged. When a drop and a clear happen in the same cycle, the bit ends up set.
- R5: The pending count is (tail − head) mod 64, which covers the case where tail is below head. Software consumes entries by writing a new head at register index 1.
- R6: The control register at register index 0 keeps only bit 0 (ring enable), bit 1 (event mode) and bit 11 (interrupt enable). All other bits read as 0.
- R7: In event mode, `irq[i]` is high exactly when the ring is enabled, its interrupt enable is set, its global enable bit is set and head ≠ tail. It falls in the cycle that follows the head write that empties the ring.
- R8: In batch mode, an accepted entry sets the ring's interrupt and a head write clears it, even if entries remain. When both happen in the same cycle, the interrupt is set.
- R9: The global enable register (ring slot 7, register index 0) holds one bit per ring. Clearing a ring's bit forces its `irq` low.
- R10: `reg_rvalid` rises exactly one cycle after `reg_rd`, carrying the state from before that edge. A tail read issued in the cycle after an accepted doorbell returns the advanced value.
- R11: Tail wraps from 63 to 0, and entries stored across the wrap can be read back at slots 63 and 0.
- R12: `db_ready` is low during reset and high at every clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell beat valid |
| db_ready | output | 1 | Doorbell beat accepted when high with valid |
| db_addr | input | 32 | Doorbell write address |
| db_data | input | 32 | Doorbell write data (low 16 bits kept) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| reg_rdata | output | 32 | Read data |
| irq | output | 6 | One level interrupt per ring |

## Verification
The assertions assume reset is held for at least one clock before any traffic arrives. They also assume software moves head only forward, and never past tail, so the count of pending entries keeps its meaning. This matters to the overflow check, which ties a new overflow flag to a count of 63 in the previous cycle. The stimulus only writes head values that lie between the current head and tail, and it always waits for reset release before it sends a doorbell or register access.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_EVT_BIT = 1;
  localparam int CTRL_IE_BIT  = 11;
  localparam int MSG_W        = 16;
  localparam int WORD_W       = 32;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_HEAD = 2'd1,
    RSEL_TAIL = 2'd2,
    RSEL_STAT = 2'd3
  } evq_rsel_e;

  typedef struct packed {
    logic en;
    logic evt;
    logic ie;
  } evq_ctrl_t;

endpackage

// File: rtl/msi_evq_decode.sv
module msi_evq_decode #(
  parameter int          NUM_Q    = 6,
  parameter int          PTR_W    = 6,
  parameter int          QIDX_W   = 3,
  parameter int          PAGE_LSB = 12,
  parameter logic [31:0] MSG_BASE = 32'h4000_0000
) (
  input  logic              fire,
  input  logic [31:0]       addr,
  output logic [NUM_Q-1:0]  hit,
  output logic [QIDX_W-1:0] qidx,
  output logic [PTR_W-1:0]  vec
);
  localparam int VEC_LSB = 2;
  localparam int Q_LSB   = VEC_LSB + PTR_W;
  localparam int HI_LSB  = Q_LSB + QIDX_W;
  localparam logic [QIDX_W-1:0] NQ_L = QIDX_W'(NUM_Q);

  logic page_ok;
  logic hi_zero;

  assign page_ok = (addr[31:PAGE_LSB] == MSG_BASE[31:PAGE_LSB]);
  assign qidx    = addr[Q_LSB +: QIDX_W];
  assign vec     = addr[VEC_LSB +: PTR_W];

  generate
    if (HI_LSB < PAGE_LSB) begin : g_hi
      assign hi_zero = (addr[PAGE_LSB-1:HI_LSB] == '0);
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_Q; i++) begin : g_hit
      assign hit[i] = fire & page_ok & hi_zero & (qidx < NQ_L) &
                      (qidx == QIDX_W'(i));
    end
  endgenerate

endmodule

// File: rtl/msi_evq_ring.sv
module msi_evq_ring
  import msi_evq_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             wr_ctrl,
  input  logic             wr_head,
  input  logic             wr_stat,
  input  evq_ctrl_t        ctrl_in,
  input  logic [PTR_W-1:0] head_in,
  input  logic             stat_clr,
  input  logic             gen,
  output evq_ctrl_t        ctrl,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             ovf,
  output logic             accept,
  output logic             irq
);
  localparam logic [PTR_W-1:0] FULL_CNT = '1;

  logic [PTR_W-1:0] pending;
  logic             full;
  logic             drop;
  logic             batch;

  assign pending = tail - head;
  assign full    = (pending == FULL_CNT);
  assign accept  = push & ctrl.en & ~full;
  assign drop    = push & ctrl.en & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      head  <= '0;
      tail  <= '0;
      ovf   <= 1'b0;
      batch <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_in;
      if (wr_head) head <= head_in;
      if (accept)  tail <= tail + 1'b1;
      if (drop)                      ovf <= 1'b1;
      else if (wr_stat && stat_clr)  ovf <= 1'b0;
      if (accept)       batch <= 1'b1;
      else if (wr_head) batch <= 1'b0;
    end
  end

  assign irq = ctrl.en & ctrl.ie & gen & (ctrl.evt ? (head != tail) : batch);

endmodule

// File: rtl/msi_evq_store.sv
module msi_evq_store #(
  parameter int NUM_Q  = 6,
  parameter int PTR_W  = 6,
  parameter int QIDX_W = 3,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [QIDX_W-1:0] wr_q,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic [QIDX_W-1:0] rd_q,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = NUM_Q << PTR_W;
  localparam int AW    = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_idx;
  logic [AW-1:0]     rd_idx;

  assign wr_idx = AW'({wr_q, wr_ptr});
  assign rd_idx = AW'({rd_q, rd_ptr});

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[rd_idx];
  end

endmodule

// File: rtl/msi_evq_ctrl.sv
module msi_evq_ctrl
  import msi_evq_pkg::*;
#(
  parameter int          NUM_Q         = 6,
  parameter int          PTR_W         = 6,
  parameter int          PAGE_LSB      = 12,
  parameter logic [31:0] MSG_BASE      = 32'h4000_0000,
  parameter bit          HAS_GLOBAL_EN = 1'b1,
  parameter int          QIDX_W        = $clog2(NUM_Q + 1),
  parameter int          REG_AW        = 1 + QIDX_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_valid,
  output logic              db_ready,
  input  logic [31:0]       db_addr,
  input  logic [31:0]       db_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              reg_rvalid,
  output logic [31:0]       reg_rdata,
  output logic [NUM_Q-1:0]  irq
);
  localparam logic [QIDX_W-1:0] NQ_L    = QIDX_W'(NUM_Q);
  localparam logic [QIDX_W-1:0] GLB_IDX = '1;
  localparam int                PAD_W   = WORD_W - MSG_W - PTR_W;

  // doorbell side
  logic                        db_fire;
  logic [NUM_Q-1:0]            dec_hit;
  logic [QIDX_W-1:0]           dec_q;
  logic [PTR_W-1:0]            dec_vec;
  logic [WORD_W-1:0]           entry_word;

  // ring state
  logic [NUM_Q-1:0]             q_en, q_evt, q_ie, q_ovf, q_acc;
  logic [NUM_Q-1:0][PTR_W-1:0]  q_head, q_tail;
  logic [NUM_Q-1:0]             gien_eff;

  // register decode
  logic              is_win;
  logic [QIDX_W-1:0] r_q;
  evq_rsel_e         r_sel;
  evq_ctrl_t         ctrl_wr;
  logic [31:0]       reg_mux;
  logic [31:0]       reg_q;
  logic              win_q;
  logic [WORD_W-1:0] ram_word;

  always_ff @(posedge clk) begin
    if (!rst_n) db_ready <= 1'b0;
    else        db_ready <= 1'b1;
  end

  assign db_fire    = db_valid & db_ready;
  assign entry_word = {{PAD_W{1'b0}}, dec_vec, db_data[MSG_W-1:0]};

  msi_evq_decode #(
    .NUM_Q(NUM_Q), .PTR_W(PTR_W), .QIDX_W(QIDX_W),
    .PAGE_LSB(PAGE_LSB), .MSG_BASE(MSG_BASE)
  ) u_dec (
    .fire(db_fire), .addr(db_addr), .hit(dec_hit), .qidx(dec_q), .vec(dec_vec)
  );

  assign is_win = reg_addr[REG_AW-1];
  assign r_q    = reg_addr[PTR_W +: QIDX_W];
  assign r_sel  = evq_rsel_e'(reg_addr[1:0]);

  always_comb begin
    ctrl_wr.en  = reg_wdata[CTRL_EN_BIT];
    ctrl_wr.evt = reg_wdata[CTRL_EVT_BIT];
    ctrl_wr.ie  = reg_wdata[CTRL_IE_BIT];
  end

  generate
    for (genvar i = 0; i < NUM_Q; i++) begin : g_ring
      logic      sel;
      evq_ctrl_t ctrl_o;
      assign sel = reg_wr & ~is_win & (r_q == QIDX_W'(i));
      msi_evq_ring #(.PTR_W(PTR_W)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push(dec_hit[i]),
        .wr_ctrl(sel & (r_sel == RSEL_CTRL)),
        .wr_head(sel & (r_sel == RSEL_HEAD)),
        .wr_stat(sel & (r_sel == RSEL_STAT)),
        .ctrl_in(ctrl_wr),
        .head_in(reg_wdata[PTR_W-1:0]),
        .stat_clr(reg_wdata[0]),
        .gen(gien_eff[i]),
        .ctrl(ctrl_o),
        .head(q_head[i]),
        .tail(q_tail[i]),
        .ovf(q_ovf[i]),
        .accept(q_acc[i]),
        .irq(irq[i])
      );
      assign q_en[i]  = ctrl_o.en;
      assign q_evt[i] = ctrl_o.evt;
      assign q_ie[i]  = ctrl_o.ie;
    end
  endgenerate

  generate
    if (HAS_GLOBAL_EN) begin : g_gien
      logic [NUM_Q-1:0] gien_q;
      always_ff @(posedge clk) begin
        if (!rst_n) gien_q <= '0;
        else if (reg_wr && !is_win && r_q == GLB_IDX && r_sel == RSEL_CTRL)
          gien_q <= reg_wdata[NUM_Q-1:0];
      end
      assign gien_eff = gien_q;
    end else begin : g_nogien
      assign gien_eff = '1;
    end
  endgenerate

  msi_evq_store #(
    .NUM_Q(NUM_Q), .PTR_W(PTR_W), .QIDX_W(QIDX_W), .WORD_W(WORD_W)
  ) u_store (
    .clk(clk),
    .wr_en(|q_acc),
    .wr_q(dec_q),
    .wr_ptr(q_tail[dec_q]),
    .wr_word(entry_word),
    .rd_en(reg_rd & is_win & (r_q < NQ_L)),
    .rd_q(r_q),
    .rd_ptr(reg_addr[PTR_W-1:0]),
    .rd_word(ram_word)
  );

  always_comb begin
    reg_mux = '0;
    if (!is_win) begin
      if (r_q < NQ_L) begin
        unique case (r_sel)
          RSEL_CTRL: begin
            reg_mux[CTRL_EN_BIT]  = q_en[r_q];
            reg_mux[CTRL_EVT_BIT] = q_evt[r_q];
            reg_mux[CTRL_IE_BIT]  = q_ie[r_q];
          end
          RSEL_HEAD: reg_mux[PTR_W-1:0] = q_head[r_q];
          RSEL_TAIL: reg_mux[PTR_W-1:0] = q_tail[r_q];
          RSEL_STAT: reg_mux[0]         = q_ovf[r_q];
          default:   reg_mux            = '0;
        endcase
      end else if (HAS_GLOBAL_EN && r_q == GLB_IDX && r_sel == RSEL_CTRL) begin
        reg_mux[NUM_Q-1:0] = gien_eff;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      win_q      <= 1'b0;
      reg_q      <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        win_q <= is_win & (r_q < NQ_L);
        reg_q <= reg_mux;
      end
    end
  end

  assign reg_rdata = win_q ? ram_word : reg_q;

endmodule

// File: rtl/msi_evq_ctrl_chk.sv
module msi_evq_ctrl_chk #(
  parameter int NUM_Q         = 6,
  parameter int PTR_W         = 6,
  parameter bit HAS_GLOBAL_EN = 1'b1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_rd,
  input logic                       reg_rvalid,
  input logic [NUM_Q-1:0]           irq,
  input logic [NUM_Q-1:0][PTR_W-1:0] q_head,
  input logic [NUM_Q-1:0][PTR_W-1:0] q_tail,
  input logic [NUM_Q-1:0]           q_en,
  input logic [NUM_Q-1:0]           q_evt,
  input logic [NUM_Q-1:0]           q_ovf,
  input logic [NUM_Q-1:0]           gien_eff
);
  localparam logic [PTR_W-1:0] FULL_CNT = '1;

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid); // R10
  AST_RVALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid); // R10

  generate
    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
      AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_tail[i]) |-> (q_tail[i] == PTR_W'($past(q_tail[i]) + 1'b1))); // R11
      AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !q_en[i] |=> $stable(q_tail[i])); // R3
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_ovf[i]) |-> ($past(PTR_W'(q_tail[i] - q_head[i])) == FULL_CNT)); // R4
      AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q_evt[i] && q_head[i] == q_tail[i]) |-> !irq[i]); // R7
      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_en[i] || !gien_eff[i]) |-> !irq[i]); // R9
    end
  endgenerate

endmodule

bind msi_evq_ctrl msi_evq_ctrl_chk #(
  .NUM_Q(NUM_Q), .PTR_W(PTR_W), .HAS_GLOBAL_EN(HAS_GLOBAL_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .irq(irq), .q_head(q_head), .q_tail(q_tail), .q_en(q_en),
  .q_evt(q_evt), .q_ovf(q_ovf), .gien_eff(gien_eff)
);

// File: tb/msi_evq_ctrl_tb_top.sv
module msi_evq_ctrl_tb_top;
  localparam int          NQ   = 6;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        db_valid = 1'b0;
  logic        db_ready;
  logic [31:0] db_addr = '0;
  logic [31:0] db_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic [NQ-1:0] irq;

  always #2 clk = ~clk;

  msi_evq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_ready(db_ready),
    .db_addr(db_addr), .db_data(db_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_checks = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  // behavioural reference state
  int          m_ctrl[NQ], m_head[NQ], m_tail[NQ], m_ovf[NQ], m_batch[NQ];
  int          m_gien;
  logic [31:0] m_mem[int];
  bit          exp_rv;
  logic [31:0] exp_rd;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int pend(int q);
    return (m_tail[q] - m_head[q] + 64) % 64;
  endfunction

  function automatic bit m_irq(int q);
    bit en  = m_ctrl[q][0];
    bit evt = m_ctrl[q][1];
    bit ie  = m_ctrl[q][11];
    bit g   = m_gien[q];
    return en && ie && g && (evt ? (m_head[q] != m_tail[q]) : (m_batch[q] != 0));
  endfunction

  function automatic logic [9:0] ra(int q, int r);
    return {1'b0, 3'(q), 4'b0, 2'(r)};
  endfunction

  function automatic logic [9:0] wa(int q, int idx);
    return {1'b1, 3'(q), 6'(idx)};
  endfunction

  task automatic model_step();
    bit acc = 0, drop = 0;
    int dq = 0;
    logic [31:0] word = '0;
    exp_rv = reg_rd;
    exp_rd = '0;
    if (reg_rd) begin
      int q = int'(reg_addr[8:6]);
      int r = int'(reg_addr[1:0]);
      if (reg_addr[9]) begin
        if (q < NQ) exp_rd = m_mem[q*64 + int'(reg_addr[5:0])];
      end else if (q < NQ) begin
        case (r)
          0: exp_rd = 32'(m_ctrl[q]);
          1: exp_rd = 32'(m_head[q]);
          2: exp_rd = 32'(m_tail[q]);
          default: exp_rd = 32'(m_ovf[q]);
        endcase
      end else if (q == 7 && r == 0) exp_rd = 32'(m_gien);
    end
    if (db_valid) begin
      dq = int'(db_addr[10:8]);
      if (db_addr[31:12] == BASE[31:12] && !db_addr[11] && dq < NQ && m_ctrl[dq][0]) begin
        if (pend(dq) == 63) drop = 1;
        else begin
          acc = 1;
          word = {10'b0, db_addr[7:2], db_data[15:0]};
        end
      end
    end
    if (reg_wr && !reg_addr[9]) begin
      int q = int'(reg_addr[8:6]);
      int r = int'(reg_addr[1:0]);
      if (q < NQ) begin
        case (r)
          0: m_ctrl[q] = int'(reg_wdata & 32'h803);
          1: begin m_head[q] = int'(reg_wdata[5:0]); m_batch[q] = 0; end
          3: if (reg_wdata[0]) m_ovf[q] = 0;
          default: ;
        endcase
      end else if (q == 7 && r == 0) m_gien = int'(reg_wdata[5:0]);
    end
    if (drop) m_ovf[dq] = 1;
    if (acc) begin
      m_mem[dq*64 + m_tail[dq]] = word;
      m_tail[dq] = (m_tail[dq] + 1) % 64;
      m_batch[dq] = 1;
    end
  endtask

  task automatic tick();
    logic [NQ-1:0] ei;
    model_step();
    @(posedge clk);
    #1;
    for (int q = 0; q < NQ; q++) ei[q] = m_irq(q);
    check(irq === ei, cur_tag, 32'(irq), 32'(ei));
    if (exp_rv) check(reg_rvalid === 1'b1 && reg_rdata === exp_rd, cur_tag, reg_rdata, exp_rd);
    else        check(reg_rvalid === 1'b0, "R10", 32'(reg_rvalid), 32'd0);
    db_valid = 0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic push(int q, int vec);
    db_addr = BASE | 32'(q << 8) | 32'(vec << 2);
    db_data = 32'(vec) | 32'hABCD_0000;
    db_valid = 1;
    tick();
  endtask

  task automatic push_raw(logic [31:0] a);
    db_addr = a; db_data = 32'h0000_0011; db_valid = 1;
    tick();
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick();
  endtask

  task automatic rd(logic [9:0] a, string tag);
    cur_tag = tag;
    reg_addr = a; reg_rd = 1;
    tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      m_ctrl[q] = 0; m_head[q] = 0; m_tail[q] = 0; m_ovf[q] = 0; m_batch[q] = 0;
    end
    m_gien = 0;
    repeat (3) @(posedge clk);
    #1;
    check(db_ready === 1'b0, "R12", 32'(db_ready), 32'd0);
    check(irq === '0, "R1", 32'(irq), 32'd0);
    rst_n = 1;
    cur_tag = "R12";
    tick();
    check(db_ready === 1'b1, "R12", 32'(db_ready), 32'd1);

    // R1 reset values
    rd(ra(0, 0), "R1"); rd(ra(0, 1), "R1"); rd(ra(0, 2), "R1"); rd(ra(0, 3), "R1");
    rd(ra(7, 0), "R1");

    // R6 control bit keeping
    wr(ra(7, 0), 32'h3f);
    rd(ra(7, 0), "R9");
    wr(ra(5, 0), 32'hffff_ffff);
    rd(ra(5, 0), "R6");
    wr(ra(5, 0), 32'h0);
    wr(ra(0, 0), 32'h803);
    rd(ra(0, 0), "R6");

    // R2 store and readback, R7 level interrupt
    cur_tag = "R7";
    push(0, 5); push(0, 9); push(0, 63);
    rd(ra(0, 2), "R2");
    rd(wa(0, 0), "R2"); rd(wa(0, 1), "R2"); rd(wa(0, 2), "R2");
    cur_tag = "R7";
    wr(ra(0, 1), 32'd1); wr(ra(0, 1), 32'd2); wr(ra(0, 1), 32'd3);
    rd(ra(0, 1), "R5");

    // R3 ignored doorbells
    cur_tag = "R3";
    push_raw(32'h4010_0000);
    push_raw(BASE | 32'h600);
    push_raw(BASE | 32'h700);
    push_raw(BASE | 32'h800);
    push(1, 4);
    rd(ra(0, 2), "R3"); rd(ra(1, 2), "R3");

    // R8 batch mode
    wr(ra(2, 0), 32'h801);
    cur_tag = "R8";
    push(2, 1); push(2, 2);
    wr(ra(2, 1), 32'd1);
    cur_tag = "R8";
    push(2, 3);
    rd(ra(2, 2), "R8");

    // R4 overflow
    wr(ra(3, 0), 32'h803);
    cur_tag = "R4";
    for (int i = 0; i < 64; i++) push(3, i % 64);
    rd(ra(3, 2), "R4"); rd(ra(3, 3), "R4");
    wr(ra(3, 3), 32'h0);
    rd(ra(3, 3), "R4");
    wr(ra(3, 3), 32'h1);
    rd(ra(3, 3), "R4");

    // R11 wrap, R5 tail below head
    wr(ra(3, 1), 32'd63);
    cur_tag = "R11";
    push(3, 40); push(3, 41); push(3, 42);
    rd(ra(3, 2), "R11");
    rd(wa(3, 63), "R11"); rd(wa(3, 0), "R11"); rd(wa(3, 1), "R11");
    cur_tag = "R5";
    wr(ra(3, 1), 32'd0); wr(ra(3, 1), 32'd1); wr(ra(3, 1), 32'd2);

    // R9 global enable gating
    cur_tag = "R9";
    push(0, 7);
    wr(ra(7, 0), 32'h3e);
    rd(ra(7, 0), "R9");
    wr(ra(7, 0), 32'h3f);

    // R10 tail read ordering
    wr(ra(4, 0), 32'h803);
    cur_tag = "R10";
    db_addr = BASE | 32'h400 | 32'h8; db_data = 32'h2; db_valid = 1;
    reg_addr = ra(4, 2); reg_rd = 1;
    tick();
    rd(ra(4, 2), "R10");
    rd(wa(4, 0), "R2");

    finish_run();
  end

endmodule